// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block resolves one branch per strobe for a 32-bit big-endian core. It takes a decoded instruction word, the address of that instruction, the condition register, the count register and the link register. From these it decides whether the branch goes, computes the next fetch address and produces the updated count register value. It also presents the return address when the instruction asks for a link.

Three branch forms are handled. The first is the unconditional form with a 24-bit word displacement. The second is the conditional form with a 14-bit word displacement. The third is the conditional form whose target comes from the link or count register. The conditional forms use a 5-bit control field (instruction bits 25..21). This field can enable a count-down test, a condition-bit test, both, or neither. All results are registered and appear one clock after the input strobe.

Top module: `br_resolve`

## Requirements
- R1: After reset every output is zero. An input accepted with `in_valid` high produces `out_valid` high exactly one clock later, and `out_valid` is low in every other cycle.
- R2: Opcode 18 (insn[31:26]) is the unconditional form and is always taken. Its offset is insn[25:2] shifted left by two, with bit 25 of the result copied into bits 31..26.
- R3: Opcode 16 is the conditional displacement form. Its offset is insn[15:2] shifted left by two, with bit 15 of the result copied into bits 31..16.
- R4: For both displacement forms, insn[1] set makes the offset itself the target. insn[1] clear makes the target `pc` plus the offset, modulo 2^32.
- R5: Count test. When insn[23] is set, the test passes and `cnt_we` is low. When insn[23] is clear, `cnt_new` = `cnt_in` - 1 and `cnt_we` is high whether or not the branch goes. The test then passes when that new value is nonzero and insn[22] is clear, or when it is zero and insn[22] is set.
- R6: Condition test. When insn[25] is set, the test passes. Otherwise it passes when `cond_in[31 - insn[20:16]]` equals insn[24].
- R7: A conditional branch is taken only when both tests pass. A branch that is not taken presents `pc` + 4 as `next_pc`.
- R8: Opcode 19 with insn[10:1] = 16 takes `lnk_in` as its target. With insn[10:1] = 528 it takes `cnt_in` (the value before any decrement). In both cases bits 1..0 of the target are forced to zero, and the tests of R5 to R7 apply.
- R9: For any branch form with insn[0] set, `lnk_we` is high and `lnk_val` = `pc` + 4. Otherwise `lnk_we` is low.
- R10: Any other instruction word gives `taken` low, `next_pc` = `pc` + 4, and both `cnt_we` and `lnk_we` low.
- R11: A decrement of a zero count gives 32'hFFFFFFFF, which counts as nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| insn | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| cond_in | input | 32 | Condition register |
| cnt_in | input | 32 | Count register |
| lnk_in | input | 32 | Link register |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch goes |
| next_pc | output | 32 | Next fetch address |
| cnt_we | output | 1 | Count register write |
| cnt_new | output | 32 | New count value |
| lnk_we | output | 1 | Link write request |
| lnk_val | output | 32 | Return address |

## Verification
On every cycle the assertions check several behaviours. They check the one-cycle strobe timing and that a decrement result equals the previous count minus one. They check that a fall-through or link value is the previous address plus four, and that a branch with both tests disabled always goes. The full taken decision over every control encoding cannot be checked that way, so the bench's scenarios cover it. Those scenarios also cover sign extension of both displacement widths, selection of the register target, and the counter wrap from zero.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int unsigned OPC_W      = 6;
    localparam logic [5:0]  OPC_UNCOND = 6'd18;
    localparam logic [5:0]  OPC_CIMM   = 6'd16;
    localparam logic [5:0]  OPC_CREG   = 6'd19;
    localparam logic [9:0]  XO_TO_LNK  = 10'd16;
    localparam logic [9:0]  XO_TO_CNT  = 10'd528;

    typedef enum logic [1:0] {
        K_NONE,
        K_UNCOND,
        K_COND_IMM,
        K_COND_REG
    } br_kind_e;
endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] lnk_in,
    input  logic [XLEN-1:0] cnt_in,
    output br_kind_e        kind,
    output logic [XLEN-1:0] target,
    output logic            link_req
);
    localparam int unsigned LI_W = 24;
    localparam int unsigned BD_W = 14;

    logic [OPC_W-1:0] opc;
    logic [9:0]       xo;
    logic [XLEN-1:0]  li_off, bd_off, imm, reg_tgt;

    assign opc = insn[31:26];
    assign xo  = insn[10:1];

    assign li_off = {{(XLEN-LI_W-2){insn[25]}}, insn[25:2], 2'b00};
    assign bd_off = {{(XLEN-BD_W-2){insn[15]}}, insn[15:2], 2'b00};

    always_comb begin
        kind = K_NONE;
        if (opc == OPC_UNCOND)
            kind = K_UNCOND;
        else if (opc == OPC_CIMM)
            kind = K_COND_IMM;
        else if (opc == OPC_CREG && (xo == XO_TO_LNK || xo == XO_TO_CNT))
            kind = K_COND_REG;
    end

    assign imm      = (kind == K_UNCOND) ? li_off : bd_off;
    assign reg_tgt  = (xo == XO_TO_LNK) ? lnk_in : cnt_in;
    assign link_req = (kind != K_NONE) && insn[0];

    always_comb begin
        if (kind == K_COND_REG)
            target = {reg_tgt[XLEN-1:2], 2'b00};
        else if (insn[1])
            target = imm;
        else
            target = pc + imm;
    end
endmodule

// File: rtl/br_cond.sv
module br_cond #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned CRW  = 32
) (
    input  logic [4:0]      ctl,
    input  logic [4:0]      sel,
    input  logic [CRW-1:0]  cond_in,
    input  logic [XLEN-1:0] cnt_in,
    output logic            pass,
    output logic            dec_en,
    output logic [XLEN-1:0] cnt_dec
);
    logic cnt_ok, cr_ok, nz;
    logic [4:0] bit_idx;

    assign dec_en  = ~ctl[2];
    assign cnt_dec = cnt_in - XLEN'(1);
    assign nz      = |cnt_dec;
    assign cnt_ok  = ctl[2] | (nz ^ ctl[1]);

    assign bit_idx = 5'(CRW - 1) - sel;
    assign cr_ok   = ctl[4] | (cond_in[bit_idx] == ctl[3]);

    assign pass    = cnt_ok & cr_ok;
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] pc,
    input  logic [31:0]     cond_in,
    input  logic [XLEN-1:0] cnt_in,
    input  logic [XLEN-1:0] lnk_in,
    output logic            out_valid,
    output logic            taken,
    output logic [XLEN-1:0] next_pc,
    output logic            cnt_we,
    output logic [XLEN-1:0] cnt_new,
    output logic            lnk_we,
    output logic [XLEN-1:0] lnk_val
);
    typedef struct packed {
        logic            vld;
        logic            tkn;
        logic [XLEN-1:0] npc;
        logic            cwe;
        logic [XLEN-1:0] cval;
        logic            lwe;
        logic [XLEN-1:0] lval;
    } res_t;

    br_kind_e        kind;
    logic [XLEN-1:0] target, seq_pc;
    logic            link_req, pass, dec_en;
    logic [XLEN-1:0] cnt_dec;
    res_t            res_d, res_q;

    br_decode #(.XLEN(XLEN)) u_dec (
        .insn(insn), .pc(pc), .lnk_in(lnk_in), .cnt_in(cnt_in),
        .kind(kind), .target(target), .link_req(link_req)
    );

    br_cond #(.XLEN(XLEN), .CRW(32)) u_cond (
        .ctl(insn[25:21]), .sel(insn[20:16]), .cond_in(cond_in),
        .cnt_in(cnt_in), .pass(pass), .dec_en(dec_en), .cnt_dec(cnt_dec)
    );

    assign seq_pc = pc + XLEN'(4);

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.lwe  = link_req;
            res_d.lval = seq_pc;
            res_d.cval = cnt_dec;
            unique case (kind)
                K_UNCOND: begin
                    res_d.tkn = 1'b1;
                    res_d.cwe = 1'b0;
                end
                K_COND_IMM, K_COND_REG: begin
                    res_d.tkn = pass;
                    res_d.cwe = dec_en;
                end
                default: begin
                    res_d.tkn = 1'b0;
                    res_d.cwe = 1'b0;
                end
            endcase
            res_d.npc = res_d.tkn ? target : seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.tkn;
    assign next_pc   = res_q.npc;
    assign cnt_we    = res_q.cwe;
    assign cnt_new   = res_q.cval;
    assign lnk_we    = res_q.lwe;
    assign lnk_val   = res_q.lval;
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     insn,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] cnt_in,
    input logic            out_valid,
    input logic            taken,
    input logic [XLEN-1:0] next_pc,
    input logic            cnt_we,
    input logic [XLEN-1:0] cnt_new,
    input logic            lnk_we,
    input logic [XLEN-1:0] lnk_val
);
    a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r5_dec_value: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!cnt_we || cnt_new == $past(cnt_in) - XLEN'(1)));
    a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_pc == $past(pc) + XLEN'(4)));
    a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!lnk_we || lnk_val == $past(pc) + XLEN'(4)));
    a_r7_both_off_goes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[31:26] == 6'd16 && insn[25] && insn[23]) |=> taken);
endmodule

bind br_resolve br_resolve_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .pc(pc),
    .cnt_in(cnt_in), .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
    .cnt_we(cnt_we), .cnt_new(cnt_new), .lnk_we(lnk_we), .lnk_val(lnk_val)
);

// File: tb/sim_br_resolve.sv
module sim_br_resolve;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0, pc = '0, cond_in = '0, cnt_in = '0, lnk_in = '0;
    logic        out_valid, taken, cnt_we, lnk_we;
    logic [31:0] next_pc, cnt_new, lnk_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    br_resolve #(.XLEN(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .pc(pc),
        .cond_in(cond_in), .cnt_in(cnt_in), .lnk_in(lnk_in),
        .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
        .cnt_we(cnt_we), .cnt_new(cnt_new), .lnk_we(lnk_we), .lnk_val(lnk_val)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected result written from the requirement text
    task automatic apply(input string req, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] c, input logic [31:0] n, input logic [31:0] l);
        logic [5:0] op;
        logic [31:0] off, tgt, dec;
        logic go, cwe, lwe, cok, rok;
        op  = w[31:26];
        dec = n - 32'd1;
        cok = w[23] || ((dec != 0) && !w[22]) || ((dec == 0) && w[22]);
        rok = w[25] || (c[31 - w[20:16]] == w[24]);
        go = 1'b0; cwe = 1'b0; lwe = 1'b0; tgt = 32'h0;
        if (op == 6'd18) begin
            off = {{6{w[25]}}, w[25:2], 2'b00};
            tgt = w[1] ? off : a + off;
            go = 1'b1; lwe = w[0];
        end else if (op == 6'd16) begin
            off = {{16{w[15]}}, w[15:2], 2'b00};
            tgt = w[1] ? off : a + off;
            go = cok && rok; cwe = !w[23]; lwe = w[0];
        end else if (op == 6'd19 && (w[10:1] == 10'd16 || w[10:1] == 10'd528)) begin
            tgt = (w[10:1] == 10'd16) ? l : n;
            tgt[1:0] = 2'b00;
            go = cok && rok; cwe = !w[23]; lwe = w[0];
        end
        @(negedge clk);
        insn = w; pc = a; cond_in = c; cnt_in = n; lnk_in = l; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "taken", 32'(taken), 32'(go));
        chk(req, "next_pc", next_pc, go ? tgt : a + 32'd4);
        chk(req, "cnt_we", 32'(cnt_we), 32'(cwe));
        if (cwe) chk(req, "cnt_new", cnt_new, dec);
        chk(req, "lnk_we", 32'(lnk_we), 32'(lwe));
        if (lwe) chk(req, "lnk_val", lnk_val, a + 32'd4);
    endtask

    task automatic t_reset();
        chk("R1", "rst out_valid", 32'(out_valid), 0);
        chk("R1", "rst taken", 32'(taken), 0);
        chk("R1", "rst next_pc", next_pc, 0);
        chk("R1", "rst cnt_we", 32'(cnt_we), 0);
        chk("R1", "rst lnk_we", 32'(lnk_we), 0);
    endtask

    task automatic t_uncond();
        apply("R2", {6'd18, 24'h000010, 2'b00}, 32'h0000_1000, 0, 5, 0);
        apply("R2", {6'd18, 24'hFFFFFF, 2'b00}, 32'h0000_1000, 0, 5, 0);
        apply("R2", {6'd18, 24'h800000, 2'b00}, 32'h0400_0000, 0, 5, 0);
        apply("R4", {6'd18, 24'h800001, 2'b10}, 32'h0000_2000, 0, 5, 0);
        apply("R4", {6'd18, 24'h000123, 2'b10}, 32'h0000_2000, 0, 5, 0);
        apply("R9", {6'd18, 24'h000040, 2'b01}, 32'h0000_3000, 0, 5, 0);
    endtask

    task automatic t_disp();
        apply("R3", {6'd16, 5'b10100, 5'd0, 14'h0008, 2'b00}, 32'h0000_8000, 0, 5, 0);
        apply("R3", {6'd16, 5'b10100, 5'd0, 14'h2000, 2'b00}, 32'h0000_8000, 0, 5, 0);
        apply("R4", {6'd16, 5'b10100, 5'd0, 14'h3FFF, 2'b10}, 32'h0000_8000, 0, 5, 0);
        apply("R4", {6'd16, 5'b10100, 5'd0, 14'h0101, 2'b10}, 32'h0000_8000, 0, 5, 0);
    endtask

    // All control encodings against three counts and matching/mismatching bits
    task automatic t_sweep();
        logic [31:0] cnts [3] = '{32'd1, 32'd2, 32'd0};
        for (int b = 0; b < 32; b++) begin
            for (int k = 0; k < 3; k++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [4:0] ctl;
                    logic bitv;
                    ctl  = 5'(b);
                    bitv = (m == 1) ? ctl[3] : ~ctl[3];
                    apply((k == 2) ? "R11" : "R5",
                          {6'd16, ctl, 5'd5, 14'h0040, 2'b00}, 32'h0001_0000,
                          32'(bitv) << 26, cnts[k], 0);
                    apply((m == 1) ? "R6" : "R7",
                          {6'd16, ctl, 5'd30, 14'h3FF0, 2'b01}, 32'h0002_0000,
                          32'(bitv) << 1, cnts[k], 0);
                end
            end
        end
    endtask

    task automatic t_reg();
        apply("R8", {6'd19, 5'b10100, 5'd0, 5'd0, 10'd16, 1'b0}, 32'h100, 0, 9, 32'h0000_ABCF);
        apply("R8", {6'd19, 5'b10100, 5'd0, 5'd0, 10'd528, 1'b1}, 32'h100, 0, 32'h0000_7777, 32'h4);
        apply("R8", {6'd19, 5'b00000, 5'd3, 5'd0, 10'd16, 1'b0}, 32'h200, 32'h0, 3, 32'h0000_5550);
        apply("R8", {6'd19, 5'b01100, 5'd3, 5'd0, 10'd528, 1'b0}, 32'h200, 32'h1000_0000, 32'h99, 0);
    endtask

    task automatic t_other();
        apply("R10", {6'd31, 26'h3FF_FFFF}, 32'h0000_0400, 32'hFFFF_FFFF, 7, 32'h88);
        apply("R10", {6'd19, 5'b10100, 5'd0, 5'd0, 10'd50, 1'b1}, 32'h0000_0500, 0, 7, 32'h88);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R1", "idle out_valid", 32'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_uncond();
        t_idle();
        t_disp();
        t_sweep();
        t_reg();
        t_other();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule